// File: doc/BRIEF.md
# Parallel NOR Flash Host Controller

This block sits between a synchronous on-chip requester and an asynchronous parallel NOR flash with a 20-bit word address and a 16-bit data bus. It accepts one read or one word-program request at a time on a valid/ready interface. It drives the chip-enable, output-enable, write-enable and reset strobes of the flash. Every strobe edge is placed by counting system clock cycles. Each count comes from a minimum time given in nanoseconds, divided by the clock period and rounded up.

After reset the controller pulses the flash reset line low and then waits out the power-up interval. Only after that does it offer `req_ready`. A read holds chip-enable and output-enable low for the longest of the cycle, address-access and output-enable access times. It samples the bus in the last cycle and returns the word with a one-cycle `rsp_valid` pulse. The controller then keeps its own bus driver off until the flash has released the bus. A program is issued as three unlock writes and then the target write. After the target write the controller waits out the word-program time before it takes a new request. The bidirectional data bus is split into `fl_dq_o`, `fl_dq_i` and an enable `fl_dq_oe` for an external tristate buffer.

With the default 8 ns period the cycle counts are as follows:

| Interval | Cycles |
|----------|--------|
| read (C_RD) | 9 |
| bus release (C_HZ) | 5 |
| write-enable low (C_WLO) | 7 |
| write-enable high (C_WHI) | 4 |
| reset pulse (C_RP) | 63 |
| power-up (C_PUW) | 12500 |
| program wait (C_BP) | 5000 |

Top module: `flc_nor_ctrl`

## Requirements
- R1: While `rst_n` is low, and for exactly C_RP = ceil(T_RP/period) cycles after it is released, `fl_rst_n` is 0. During that time `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0 and `req_ready` is 0.
- R2: `req_ready` first goes high exactly C_RP + max(ceil(T_PU), ceil(T_RHR)) cycles after reset release.
- R3: A read (`req_op`=0) holds `fl_ce_n` and `fl_oe_n` low with the request address on `fl_addr` for C_RD cycles. C_RD is the maximum of the ceilings of T_RC, T_AA and T_OE. `rsp_valid` is a one-cycle pulse in the cycle after output-enable rises.
- R4: `fl_dq_oe` is never 1 while `fl_oe_n` is 0. It also stays 0 for at least C_HZ = ceil(T_HZ) cycles after `fl_oe_n` rises.
- R5: A program (`req_op`=1) issues exactly four writes, in this order: data 0x00AA to address 0x05555, data 0x0055 to 0x02AAA, data 0x00A0 to 0x05555, then the request data to the request address. The upper byte of each unlock word is driven as 0x00.
- R6: Each write holds `fl_we_n` low for at least C_WLO cycles. C_WLO is the maximum of the ceilings of T_WP, T_DS and T_AH. Address and data are driven, with `fl_ce_n` low, one cycle before `fl_we_n` falls and stay constant until it rises.
- R7: Within a program `fl_we_n` stays high for at least max(ceil(T_WPH), ceil(T_OEH)) cycles between writes. `fl_oe_n` is 1 whenever `fl_we_n` is 0.
- R8: After the fourth write rises, `fl_ce_n` stays high and `req_ready` stays 0 for at least C_BP = ceil(T_BP) cycles.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the following cycle.
- R10: A read of an address returns the word last programmed there, and `rsp_data` equals the value on `fl_dq_i` in the last read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 1 | 0 = read, 1 = word program |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Word to program |
| rsp_data | output | 16 | Word read from the flash |
| rsp_valid | output | 1 | One-cycle pulse marking `rsp_data` valid |
| fl_addr | output | 20 | Flash address bus |
| fl_dq_o | output | 16 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the external data tristate |
| fl_dq_i | input | 16 | Data bus as seen from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_rst_n | output | 1 | Flash hardware reset, active low |

## Verification
The bench uses a small behavioural flash that commits a word only when it sees the full unlock pattern. A wrong unlock address or data word, or a wrong order, therefore shows up as a stale read-back, as well as in the captured write log. The bench measures every write-enable low and high run, every read window and every interval between a read and the next bus drive. A divide that rounds down, or a timer loaded one short, makes a strobe too brief and is reported against the matching requirement. A reset in the middle of a program must return all strobes to idle at once and rerun the full reset and power-up count. A design that resumed early or kept driving the bus would fail the exact cycle counts. The bench also counts the cycles after the final write before chip-enable falls again, which catches a program wait that ends too early.

// File: rtl/flc_pkg.sv
package flc_pkg;

  typedef enum logic [3:0] {
    S_RST, S_PU, S_IDLE, S_RD, S_RHZ, S_WSU, S_WLO, S_WHI, S_BUSY
  } flc_state_e;

  localparam logic [19:0] UNLK_ADDR_A = 20'h05555;
  localparam logic [19:0] UNLK_ADDR_B = 20'h02AAA;
  localparam logic [7:0]  UNLK_KEY0   = 8'hAA;
  localparam logic [7:0]  UNLK_KEY1   = 8'h55;
  localparam logic [7:0]  UNLK_KEY2   = 8'hA0;

  // ceiling division of a time by the clock period, never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flc_timer.sv
module flc_timer #(
  parameter int            CW      = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  // R8
  load_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> last);
endmodule

// File: rtl/flc_wr_sel.sv
module flc_wr_sel
  import flc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic [1:0]    idx,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);
  localparam int HI = DW - 8;

  always_comb begin
    case (idx)
      2'd0: begin bus_addr = AW'(UNLK_ADDR_A); bus_data = {{HI{1'b0}}, UNLK_KEY0}; end
      2'd1: begin bus_addr = AW'(UNLK_ADDR_B); bus_data = {{HI{1'b0}}, UNLK_KEY1}; end
      2'd2: begin bus_addr = AW'(UNLK_ADDR_A); bus_data = {{HI{1'b0}}, UNLK_KEY2}; end
      default: begin bus_addr = op_addr; bus_data = op_data; end
    endcase
  end
endmodule

// File: rtl/flc_seq.sv
module flc_seq
  import flc_pkg::*;
#(
  parameter int          AW    = 20,
  parameter int          DW    = 16,
  parameter int          CW    = 14,
  parameter int unsigned C_RD  = 9,
  parameter int unsigned C_HZ  = 5,
  parameter int unsigned C_WLO = 7,
  parameter int unsigned C_WHI = 4,
  parameter int unsigned C_BP  = 5000,
  parameter int unsigned C_PUW = 12500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] fl_dq_i,
  input  logic          tmr_last,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          req_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_valid,
  output logic [1:0]    wr_idx,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fl_rst_n,
  output logic          fl_dq_oe
);
  flc_state_e    state_q, state_d;
  logic [1:0]    idx_q, idx_d;
  logic          take, cap;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    cap      = 1'b0;
    case (state_q)
      S_RST: if (tmr_last) begin
        state_d = S_PU; tmr_load = 1'b1; tmr_val = CW'(C_PUW - 1);
      end
      S_PU:  if (tmr_last) state_d = S_IDLE;
      S_IDLE: if (req_valid) begin
        take     = 1'b1;
        tmr_load = 1'b1;
        if (req_op) begin
          state_d = S_WSU; idx_d = 2'd0; tmr_val = '0;
        end else begin
          state_d = S_RD; idx_d = 2'd3; tmr_val = CW'(C_RD - 1);
        end
      end
      S_RD: if (tmr_last) begin
        cap = 1'b1; state_d = S_RHZ; tmr_load = 1'b1; tmr_val = CW'(C_HZ - 1);
      end
      S_RHZ: if (tmr_last) state_d = S_IDLE;
      S_WSU: if (tmr_last) begin
        state_d = S_WLO; tmr_load = 1'b1; tmr_val = CW'(C_WLO - 1);
      end
      S_WLO: if (tmr_last) begin
        state_d = S_WHI; tmr_load = 1'b1; tmr_val = CW'(C_WHI - 1);
      end
      S_WHI: if (tmr_last) begin
        tmr_load = 1'b1;
        if (idx_q == 2'd3) begin
          state_d = S_BUSY; tmr_val = CW'(C_BP - 1);
        end else begin
          state_d = S_WSU; idx_d = idx_q + 2'd1; tmr_val = '0;
        end
      end
      S_BUSY: if (tmr_last) state_d = S_IDLE;
      default: state_d = S_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_RST;
      idx_q    <= 2'd3;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      rvalid_q <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= fl_dq_i;
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_data  = rdata_q;
  assign rsp_valid = rvalid_q;
  assign wr_idx    = idx_q;
  assign op_addr   = addr_q;
  assign op_wdata  = wdata_q;
  assign fl_rst_n  = (state_q != S_RST);
  assign fl_oe_n   = (state_q != S_RD);
  assign fl_we_n   = (state_q != S_WLO);
  assign fl_dq_oe  = (state_q == S_WSU) || (state_q == S_WLO) || (state_q == S_WHI);
  assign fl_ce_n   = !((state_q == S_RD) || fl_dq_oe);

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe && !req_ready);
  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
  // R7
  oe_high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_oe_n && !fl_ce_n && fl_dq_oe);
  // R3
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!fl_oe_n) && fl_oe_n);
  // R9
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: rtl/flc_nor_ctrl.sv
module flc_nor_ctrl
  import flc_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_HZ_NS       = 40,
  parameter int T_WP_NS       = 50,
  parameter int T_WPH_NS      = 30,
  parameter int T_DS_NS       = 50,
  parameter int T_AH_NS       = 50,
  parameter int T_OEH_NS      = 10,
  parameter int T_BP_NS       = 40000,
  parameter int T_RP_NS       = 500,
  parameter int T_RHR_NS      = 50,
  parameter int T_PU_NS       = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fl_rst_n
);
  localparam int unsigned P     = CLK_PERIOD_NS;
  localparam int unsigned C_RD  = umax(umax(ns2cyc(T_RC_NS, P), ns2cyc(T_AA_NS, P)), ns2cyc(T_OE_NS, P));
  localparam int unsigned C_HZ  = ns2cyc(T_HZ_NS, P);
  localparam int unsigned C_WLO = umax(umax(ns2cyc(T_WP_NS, P), ns2cyc(T_DS_NS, P)), ns2cyc(T_AH_NS, P));
  localparam int unsigned C_WHI = umax(ns2cyc(T_WPH_NS, P), ns2cyc(T_OEH_NS, P));
  localparam int unsigned C_BP  = ns2cyc(T_BP_NS, P);
  localparam int unsigned C_RP  = ns2cyc(T_RP_NS, P);
  localparam int unsigned C_PUW = umax(ns2cyc(T_PU_NS, P), ns2cyc(T_RHR_NS, P));
  localparam int unsigned C_MAX = umax(umax(umax(C_RD, C_HZ), umax(C_WLO, C_WHI)),
                                       umax(umax(C_BP, C_RP), C_PUW));
  localparam int          CW    = $clog2(C_MAX + 1);

  logic          tmr_load, tmr_last;
  logic [CW-1:0] tmr_val;
  logic [1:0]    wr_idx;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;

  flc_timer #(.CW(CW), .RST_VAL(CW'(C_RP - 1))) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  flc_seq #(
    .AW(AW), .DW(DW), .CW(CW), .C_RD(C_RD), .C_HZ(C_HZ), .C_WLO(C_WLO),
    .C_WHI(C_WHI), .C_BP(C_BP), .C_PUW(C_PUW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .fl_dq_i(fl_dq_i),
    .tmr_last(tmr_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .req_ready(req_ready), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .wr_idx(wr_idx), .op_addr(op_addr), .op_wdata(op_wdata),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_rst_n(fl_rst_n), .fl_dq_oe(fl_dq_oe)
  );

  flc_wr_sel #(.AW(AW), .DW(DW)) u_sel (
    .idx(wr_idx), .op_addr(op_addr), .op_data(op_wdata),
    .bus_addr(fl_addr), .bus_data(fl_dq_o)
  );

  // R6
  we_low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n && $past(!fl_ce_n) |-> $stable(fl_addr) && $stable(fl_dq_o));
endmodule

// File: tb/test_flc_nor_ctrl.sv
module test_flc_nor_ctrl;
  localparam int P = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RP  = cyc(500);
  localparam int E_PUW = mx(cyc(100000), cyc(50));
  localparam int E_RD  = mx(mx(cyc(70), cyc(70)), cyc(35));
  localparam int E_HZ  = cyc(40);
  localparam int E_WLO = mx(mx(cyc(50), cyc(50)), cyc(50));
  localparam int E_WHI = mx(cyc(30), cyc(10));
  localparam int E_BP  = cyc(40000);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n;
  logic [15:0] rsp_data, fl_dq_o, fl_dq_i;
  logic [19:0] fl_addr;

  flc_nor_ctrl i_flc_nor_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // behavioural flash: small memory, commits only after the unlock pattern
  logic [15:0] mem [256];
  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ? mem[fl_addr[7:0]] : 16'h0000;

  logic [19:0] la [4];
  logic [15:0] ld [4];
  logic [19:0] cur_a, prv_a;
  logic [15:0] cur_d, prv_d;
  bit prv_we, prv_ce, prv_oe, prv_dqoe;
  int we_lo, we_hi, oe_lo, since_oe, bp_cnt;
  bit hi_valid, bp_arm;
  int v_wlo, v_stab, v_whi, v_rd, v_hz, v_cont, v_bp;

  always @(negedge clk) begin
    if (!rst_n) begin
      prv_we = 1'b1; prv_ce = 1'b1; prv_oe = 1'b1; prv_dqoe = 1'b0;
      we_lo = 0; we_hi = 0; oe_lo = 0; since_oe = 1000; hi_valid = 1'b0; bp_arm = 1'b0;
    end else begin
      // R4 contention and bus release
      if (fl_dq_oe && !fl_oe_n) v_cont++;
      if (fl_dq_oe && since_oe < E_HZ) v_hz++;
      if (!fl_oe_n) begin oe_lo++; since_oe = 0; end
      else begin
        if (!prv_oe && oe_lo < E_RD) v_rd++;
        if (!prv_oe) oe_lo = 0;
        if (since_oe < 1000) since_oe++;
      end
      // R6 write enable low run and stability
      if (!fl_we_n) begin
        if (prv_we) begin
          if (prv_ce || !prv_dqoe || prv_a != fl_addr || prv_d != fl_dq_o) v_stab++;
          if (hi_valid && we_hi < E_WHI) v_whi++;
        end else if (prv_a != fl_addr || prv_d != fl_dq_o) v_stab++;
        we_lo++; cur_a = fl_addr; cur_d = fl_dq_o;
      end else begin
        if (!prv_we) begin
          if (we_lo < E_WLO) v_wlo++;
          we_lo = 0; we_hi = 0; hi_valid = 1'b1;
          for (int k = 0; k < 3; k++) begin la[k] = la[k+1]; ld[k] = ld[k+1]; end
          la[3] = cur_a; ld[3] = cur_d;
          if (la[0] == 20'h05555 && ld[0][7:0] == 8'hAA && la[1] == 20'h02AAA &&
              ld[1][7:0] == 8'h55 && la[2] == 20'h05555 && ld[2][7:0] == 8'hA0) begin
            mem[cur_a[7:0]] = cur_d;
            bp_arm = 1'b1; bp_cnt = 0;
          end
        end else we_hi++;
      end
      if (fl_ce_n) hi_valid = 1'b0;
      // R8 program wait
      if (bp_arm) begin
        if (fl_ce_n) bp_cnt++;
        if (req_ready && bp_cnt < E_BP) v_bp++;
        if (!fl_ce_n && bp_cnt > 0) begin
          if (bp_cnt < E_BP) v_bp++;
          bp_arm = 1'b0;
        end
      end
      prv_we = fl_we_n; prv_ce = fl_ce_n; prv_oe = fl_oe_n; prv_dqoe = fl_dq_oe;
      prv_a = fl_addr; prv_d = fl_dq_o;
    end
  end

  task automatic accept(input logic op, input logic [19:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic measure_reset();
    int lo, wt;
    lo = 0; wt = 0;
    rst_n = 1'b1;
    while (!req_ready && wt < 20000) begin
      if (!fl_rst_n) lo++;
      wt++;
      @(negedge clk);
    end
    chk(lo == E_RP, "R1", "flash reset low cycles", lo, E_RP);
    chk(wt == E_RP + E_PUW, "R2", "cycles to ready", wt, E_RP + E_PUW);
  endtask

  // {op, addr, wdata, expected read}
  localparam logic [52:0] VEC [8] = '{
    {1'b0, 20'h00010, 16'h0000, 16'h2CEF},
    {1'b1, 20'h00010, 16'hBEEF, 16'h0000},
    {1'b0, 20'h00010, 16'h0000, 16'hBEEF},
    {1'b1, 20'hFFFFF, 16'h8001, 16'h0000},
    {1'b0, 20'hFFFFF, 16'h0000, 16'h8001},
    {1'b0, 20'h00011, 16'h0000, 16'h2DEE},
    {1'b1, 20'h00000, 16'h0000, 16'h0000},
    {1'b0, 20'h00000, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h3C, ~8'(i)};
    for (int i = 0; i < 4; i++) begin la[i] = '0; ld[i] = '0; end
    v_wlo = 0; v_stab = 0; v_whi = 0; v_rd = 0; v_hz = 0; v_cont = 0; v_bp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({fl_rst_n, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready} == 6'b011100,
        "R1", "strobes in reset", int'({fl_rst_n, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready}), 'h1C);
    measure_reset();

    foreach (VEC[i]) begin
      logic [52:0] v;
      v = VEC[i];
      accept(v[52], v[51:32], v[31:16]);
      if (!v[52]) begin
        int w;
        w = 0;
        while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
        chk(rsp_data == v[15:0], "R10", "read data", int'(rsp_data), int'(v[15:0]));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3", "rsp_valid single pulse", int'(rsp_valid), 0);
      end else begin
        while (!req_ready) @(negedge clk);
        chk(la[0] == 20'h05555 && ld[0] == 16'h00AA && la[1] == 20'h02AAA &&
            ld[1] == 16'h0055 && la[2] == 20'h05555 && ld[2] == 16'h00A0 &&
            la[3] == v[51:32] && ld[3] == v[31:16],
            "R5", "unlock write log", int'(ld[3]), int'(v[31:16]));
      end
    end

    chk(v_rd == 0,   "R3", "short read windows", v_rd, 0);
    chk(v_cont == 0, "R4", "drive while output enabled", v_cont, 0);
    chk(v_hz == 0,   "R4", "drive before bus release", v_hz, 0);
    chk(v_wlo == 0,  "R6", "short write pulses", v_wlo, 0);
    chk(v_stab == 0, "R6", "address/data not stable", v_stab, 0);
    chk(v_whi == 0,  "R7", "short high between writes", v_whi, 0);
    chk(v_bp == 0,   "R8", "early end of program wait", v_bp, 0);

    // reset in the middle of a program write
    accept(1'b1, 20'h00020, 16'h1234);
    while (fl_we_n) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({fl_rst_n, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready} == 6'b011100,
        "R1", "strobes after mid-program reset",
        int'({fl_rst_n, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe, req_ready}), 'h1C);
    @(negedge clk);
    measure_reset();
    accept(1'b0, 20'h00020, 16'h0000);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == 16'h1CDF, "R10", "interrupted program not committed", int'(rsp_data), 'h1CDF);
    finish_run();
  end
endmodule